// File: doc/BRIEF.md
# Dual-Clock Timer with Deferred Register Transfer

This block is an 8-bit timer/counter whose counting logic may run from either the system bus clock or a separate, unrelated clock input. Software reaches it through a small register interface in the bus clock domain. Writes to the counter, to two compare registers and to two control registers land first in bus-side holding registers. Each holding register then hands its value to the timer clock domain through its own toggle handshake. While a hand-off is in flight, the register is marked busy and further writes to it are refused.

A status register shows the five busy flags, the applied clock-source select and an external-clock enable bit. An interrupt-flag register holds the overflow flag and a sticky write-collision bit. The overflow event is produced in the timer domain and carried back to the bus domain as a toggle, so each overflow sets the flag exactly once. An interrupt request is raised from that flag, a mask bit and a global enable. A change of clock source is held back until no hand-off is pending.

The bus interface is a plain register port with no back-pressure. A write completes in the cycle it is strobed, and a read returns combinational data for the address presented. The timer-domain outputs (`tmr_count`, the compare hits) are for observation and change on the selected timer clock.

Top module: `atx_top`

## Requirements
- R1: After reset every readable register (addresses 0 to 7) reads 0x00, `irq` is 0 and `tmr_count` is 0.
- R2: A write to address 0 (counter), 1 (compare A), 2 (compare B), 3 (control A) or 4 (control B) while that register is not busy is accepted. From the next cycle, its busy flag reads 1 at status (address 5) bit 4, 3, 2, 1 or 0 respectively, and the address reads back the written value.
- R3: A busy flag clears by itself once the value has been taken over in the timer domain. After it clears, the value is live: the counter shows it on `tmr_count` when stopped, and the compare values drive `cmp_a_hit`/`cmp_b_hit` (high while `tmr_count` equals the live compare value).
- R4: A write to addresses 0 to 4 while that register's busy flag is 1 is ignored, and the held value is unchanged. It sets the collision bit at address 7 bit 1, which stays set until a 1 is written to that bit.
- R5: Status bit 7 always reads 0. Status bits 4 to 0 are read-only: writing address 5 does not change them.
- R6: Status bit 5 selects the timer clock: 0 is the bus clock `clk`, 1 is `tclk_async`. A new value written there is applied only in a cycle where all busy flags are 0 and no register write is accepted. Status reads the applied value.
- R7: Status bit 6 is a plain read/write external-clock enable bit.
- R8: With control B bit 0 = 1 (run) and control A bit 0 = 0 (up counting), the counter advances once per timer clock edge. It sets the overflow flag (address 7 bit 0) once at each wrap from 0xFF to 0x00.
- R9: With control A bit 0 = 1, the counter counts up to 0xFF and then down to 0x00 and back up. The overflow flag is set only at the turn at 0x00, never at 0xFF. A counter load restarts the count in the upward direction.
- R10: The overflow flag clears when a 1 is written to address 7 bit 0, or when `irq_ack` is 1 for a cycle. A new overflow in the same cycle wins over the clear.
- R11: `irq` is 1 exactly when the overflow flag, the mask bit (address 6 bit 0) and `gie` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus/system clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized per domain |
| tclk_async | input | 1 | Alternative timer clock, unrelated to `clk` |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced; clears the overflow flag |
| irq | output | 1 | Overflow interrupt request |
| tmr_count | output | 8 | Live counter value (timer domain) |
| cmp_a_hit | output | 1 | Counter equals live compare A (timer domain) |
| cmp_b_hit | output | 1 | Counter equals live compare B (timer domain) |

## Verification
A hand-off that never completes shows as a busy flag that stays at 1 in status, and the next write to that register then sets the collision bit. A hand-off that carries the wrong value shows on `tmr_count` or a compare hit as soon as the flag drops, a few timer clocks after the write. A lost or doubled overflow toggle shows as a flag that fails to set within one count period, or that sets again after being cleared before the next wrap. A clock select applied too early or not at all shows in the count rate measured against each clock within tens of cycles.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int DW     = 8;
  localparam int N_CHAN = 5;

  typedef enum logic [2:0] {
    A_CNT  = 3'd0,
    A_CMPA = 3'd1,
    A_CMPB = 3'd2,
    A_CTLA = 3'd3,
    A_CTLB = 3'd4,
    A_STAT = 3'd5,
    A_IMSK = 3'd6,
    A_IFLG = 3'd7
  } reg_addr_e;

  localparam int ST_RSV    = 7;
  localparam int ST_EXT    = 6;
  localparam int ST_SEL    = 5;
  localparam int IF_OVF    = 0;
  localparam int IF_COLL   = 1;
  localparam int IM_OVF    = 0;
  localparam int CTLA_UPDN = 0;
  localparam int CTLB_RUN  = 0;
endpackage

// File: rtl/atx_sync.sv
module atx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/atx_rst_sync.sv
module atx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr <= '0;
    else         sr <= {sr[STAGES-2:0], 1'b1};
  end

  assign srst_n = sr[STAGES-1];
endmodule

// File: rtl/atx_chan.sv
// One holding register and its toggle handshake into the timer domain.
module atx_chan #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         bclk,
  input  logic         brst_n,
  input  logic         accept,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic [W-1:0] hold,
  input  logic         tclk,
  input  logic         trst_n,
  output logic         t_load,
  output logic [W-1:0] t_val
);
  logic req, ack_s;
  logic req_s, req_seen;

  // bus side: capture and toggle the request
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      hold <= '0;
      req  <= 1'b0;
    end else if (accept) begin
      hold <= wdata;
      req  <= ~req;
    end
  end

  atx_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(bclk), .rst_n(brst_n), .d(req_seen), .q(ack_s)
  );

  assign busy = req ^ ack_s;

  // timer side: a new request level means hold is stable and may be taken
  atx_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(tclk), .rst_n(trst_n), .d(req), .q(req_s)
  );

  assign t_load = req_s ^ req_seen;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      req_seen <= 1'b0;
      t_val    <= '0;
    end else begin
      req_seen <= req_s;
      if (t_load) t_val <= hold;
    end
  end
endmodule

// File: rtl/atx_core.sv
// Timer-domain counter with up and up/down modes.
module atx_core #(
  parameter int W = 8
) (
  input  logic         tclk,
  input  logic         trst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         updown,
  input  logic         run,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         hit_a,
  output logic         hit_b,
  output logic         ovf_tgl
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic dir_dn;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      count   <= '0;
      dir_dn  <= 1'b0;
      ovf_tgl <= 1'b0;
    end else if (load) begin
      count  <= load_val;
      dir_dn <= 1'b0;
    end else if (run) begin
      if (!updown) begin
        dir_dn <= 1'b0;
        count  <= count + ONE;
        if (count == TOP) ovf_tgl <= ~ovf_tgl;
      end else if (!dir_dn) begin
        if (count == TOP) begin
          dir_dn <= 1'b1;
          count  <= count - ONE;
        end else begin
          count <= count + ONE;
        end
      end else begin
        if (count == '0) begin
          dir_dn  <= 1'b0;
          count   <= ONE;
          ovf_tgl <= ~ovf_tgl;
        end else begin
          count <= count - ONE;
        end
      end
    end else if (!updown) begin
      dir_dn <= 1'b0;
    end
  end

  assign hit_a = (count == cmp_a);
  assign hit_b = (count == cmp_b);
endmodule

// File: rtl/atx_top.sv
module atx_top
  import atx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk_async,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gie,
  input  logic          irq_ack,
  output logic          irq,
  output logic [DW-1:0] tmr_count,
  output logic          cmp_a_hit,
  output logic          cmp_b_hit
);
  localparam int NCH = N_CHAN;

  logic b_rst_n, t_rst_n, tmr_clk;
  logic sel_now, sel_want, ext_en, ovf_ie, ovf_flag, coll_flag;
  logic ovf_tgl, ovf_s, ovf_prev, ovf_pulse;
  logic collide, iflg_wr, stat_wr, imsk_wr;

  logic [NCH-1:0] busy, wr_hit, accept, t_load, busy_stat;
  logic [DW-1:0]  hold  [NCH];
  logic [DW-1:0]  t_val [NCH];

  // timer clock source; switched only while no hand-off is pending
  assign tmr_clk = sel_now ? tclk_async : clk;

  atx_rst_sync #(.STAGES(SYNC_STAGES)) u_brst (
    .clk(clk), .arst_n(rst_n), .srst_n(b_rst_n)
  );
  atx_rst_sync #(.STAGES(SYNC_STAGES)) u_trst (
    .clk(tmr_clk), .arst_n(rst_n), .srst_n(t_rst_n)
  );

  // per-register transfer channels
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_hit[i]            = bus_wr && (bus_addr == 3'(i));
    assign accept[i]            = wr_hit[i] && !busy[i];
    assign busy_stat[NCH-1-i]   = busy[i];

    atx_chan #(.W(DW), .STAGES(SYNC_STAGES)) u_chan (
      .bclk  (clk),
      .brst_n(b_rst_n),
      .accept(accept[i]),
      .wdata (bus_wdata),
      .busy  (busy[i]),
      .hold  (hold[i]),
      .tclk  (tmr_clk),
      .trst_n(t_rst_n),
      .t_load(t_load[i]),
      .t_val (t_val[i])
    );
  end

  assign collide = |(wr_hit & busy);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign imsk_wr = bus_wr && (bus_addr == A_IMSK);
  assign iflg_wr = bus_wr && (bus_addr == A_IFLG);

  // counter loads straight from its holding register, which is frozen while busy
  atx_core #(.W(DW)) u_core (
    .tclk    (tmr_clk),
    .trst_n  (t_rst_n),
    .load    (t_load[A_CNT]),
    .load_val(hold[A_CNT]),
    .updown  (t_val[A_CTLA][CTLA_UPDN]),
    .run     (t_val[A_CTLB][CTLB_RUN]),
    .cmp_a   (t_val[A_CMPA]),
    .cmp_b   (t_val[A_CMPB]),
    .count   (tmr_count),
    .hit_a   (cmp_a_hit),
    .hit_b   (cmp_b_hit),
    .ovf_tgl (ovf_tgl)
  );

  logic unused_bits;
  assign unused_bits = ^{t_val[A_CNT], t_val[A_CTLA][DW-1:1], t_val[A_CTLB][DW-1:1],
                         t_load[NCH-1:1]};

  // overflow toggle back into the bus domain
  atx_sync #(.STAGES(SYNC_STAGES)) u_ovf_sync (
    .clk(clk), .rst_n(b_rst_n), .d(ovf_tgl), .q(ovf_s)
  );
  assign ovf_pulse = ovf_s ^ ovf_prev;

  always_ff @(posedge clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      ovf_prev  <= 1'b0;
      ovf_flag  <= 1'b0;
      coll_flag <= 1'b0;
      ovf_ie    <= 1'b0;
      ext_en    <= 1'b0;
      sel_want  <= 1'b0;
      sel_now   <= 1'b0;
    end else begin
      ovf_prev <= ovf_s;

      if (ovf_pulse)                                   ovf_flag <= 1'b1;
      else if (irq_ack || (iflg_wr && bus_wdata[IF_OVF])) ovf_flag <= 1'b0;

      if (collide)                                     coll_flag <= 1'b1;
      else if (iflg_wr && bus_wdata[IF_COLL])          coll_flag <= 1'b0;

      if (imsk_wr) ovf_ie <= bus_wdata[IM_OVF];

      if (stat_wr) begin
        ext_en   <= bus_wdata[ST_EXT];
        sel_want <= bus_wdata[ST_SEL];
      end

      if ((busy == '0) && (accept == '0)) sel_now <= sel_want;
    end
  end

  assign irq = ovf_flag && ovf_ie && gie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT, A_CMPA, A_CMPB, A_CTLA, A_CTLB: bus_rdata = hold[bus_addr];
      A_STAT: begin
        bus_rdata[ST_RSV]  = 1'b0;
        bus_rdata[ST_EXT]  = ext_en;
        bus_rdata[ST_SEL]  = sel_now;
        bus_rdata[NCH-1:0] = busy_stat;
      end
      A_IMSK: bus_rdata[IM_OVF] = ovf_ie;
      A_IFLG: begin
        bus_rdata[IF_OVF]  = ovf_flag;
        bus_rdata[IF_COLL] = coll_flag;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
  input logic       clk,
  input logic       b_rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       gie,
  input logic       irq_ack,
  input logic       irq,
  input logic [4:0] busy,
  input logic       sel_now,
  input logic       ovf_flag,
  input logic       ovf_ie,
  input logic       coll_flag,
  input logic       ovf_pulse
);
  logic [7:0] busy_pad;
  assign busy_pad = {3'b000, busy};

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    (bus_wr && bus_addr < 3'd5 && !busy_pad[bus_addr]) |=> busy_pad[$past(bus_addr)]);

  // R4
  collide_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    (bus_wr && bus_addr < 3'd5 && busy_pad[bus_addr]) |=> coll_flag);

  // R5
  stat_rsv_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    (bus_addr == 3'd5) |-> !bus_rdata[7]);

  // R6
  sel_idle_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    !$stable(sel_now) |-> ($past(busy) == 5'd0));

  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    $rose(ovf_flag) |-> $past(ovf_pulse));

  // R10
  ack_clr_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    (irq_ack && !ovf_pulse) |=> !ovf_flag);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!b_rst_n)
    irq |-> (gie && ovf_ie && ovf_flag));
endmodule

bind atx_top atx_checker u_atx_checker (
  .clk      (clk),
  .b_rst_n  (b_rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rdata(bus_rdata),
  .gie      (gie),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .busy     (busy),
  .sel_now  (sel_now),
  .ovf_flag (ovf_flag),
  .ovf_ie   (ovf_ie),
  .coll_flag(coll_flag),
  .ovf_pulse(ovf_pulse)
);

// File: tb/atx_top_bench.sv
`timescale 1ns/1ps
module atx_top_bench;
  logic       clk = 1'b0, tclk_async = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, gie = 1'b0, irq_ack = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, tmr_count;
  logic       irq, cmp_a_hit, cmp_b_hit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5  clk = ~clk;
  always #18.5 tclk_async = ~tclk_async;

  atx_top u_atx_top (
    .clk(clk), .rst_n(rst_n), .tclk_async(tclk_async),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie(gie), .irq_ack(irq_ack), .irq(irq),
    .tmr_count(tmr_count), .cmp_a_hit(cmp_a_hit), .cmp_b_hit(cmp_b_hit)
  );

  function automatic logic [7:0] stat_exp(logic ext, logic sel, logic [4:0] bsy);
    return {1'b0, ext, sel, bsy};
  endfunction

  function automatic logic [7:0] busy_bit(int ch);
    return 8'(1 << (4 - ch));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    int n = 0;
    do begin bread(3'd5, s); n++; end while (s[4:0] != 5'd0 && n < 3000);
    chk(s[4:0] == 5'd0, tag, s, 0);
  endtask

  task automatic wait_flag(input string tag);
    logic [7:0] f;
    int n = 0;
    do begin bread(3'd7, f); n++; end while (!f[0] && n < 20000);
    chk(f[0], tag, f[0], 1);
  endtask

  task automatic load_check(input logic [7:0] v, input string tag);
    bwrite(3'd0, v);
    wait_idle({tag, " idle"});
    chk(tmr_count == v, tag, tmr_count, v);
  endtask

  initial begin
    logic [7:0] r, v, a, b;
    int n;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      bread(3'(i), r);
      chk(r == 8'h00, "R1 reg reset", r, 0);
    end
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(tmr_count == 8'h00, "R1 count", tmr_count, 0);

    // R7 external-clock enable
    bwrite(3'd5, 8'h40);
    bread(3'd5, r); chk(r == stat_exp(1, 0, 0), "R7 ext set", r, stat_exp(1, 0, 0));
    bwrite(3'd5, 8'h00);
    bread(3'd5, r); chk(r == stat_exp(0, 0, 0), "R7 ext clr", r, 0);

    // R2 busy set, readback; R3 clear
    bwrite(3'd1, 8'h5A);
    bread(3'd5, r); chk(r == busy_bit(1), "R2 busy cmpA", r, busy_bit(1));
    bread(3'd1, r); chk(r == 8'h5A, "R2 readback", r, 8'h5A);
    wait_idle("R3 clear");

    // R4 collision
    bwrite(3'd1, 8'h11);
    bwrite(3'd1, 8'h22);
    bread(3'd7, r); chk(r[1], "R4 coll set", r, 2);
    wait_idle("R4 idle");
    bread(3'd1, r); chk(r == 8'h11, "R4 ignored", r, 8'h11);
    bwrite(3'd7, 8'h02);
    bread(3'd7, r); chk(r == 8'h00, "R4 coll clear", r, 0);

    // R5 read-only and reserved bits
    bwrite(3'd5, 8'h9F);
    bread(3'd5, r); chk(r == 8'h00, "R5 ro bits", r, 0);

    // R3 random loads and compares, bus clock
    for (int k = 0; k < 12; k++) begin
      v = 8'($urandom);
      load_check(v, "R3 cnt sync");
      bwrite(3'd1, v); bwrite(3'd2, v ^ 8'h01); wait_idle("R3 cmp idle");
      chk(cmp_a_hit == 1'b1, "R3 hitA", cmp_a_hit, 1);
      chk(cmp_b_hit == 1'b0, "R3 missB", cmp_b_hit, 0);
    end

    // R6 bus clock rate
    bwrite(3'd4, 8'h01); wait_idle("R6 run idle");
    @(negedge clk); a = tmr_count;
    repeat (40) @(negedge clk); b = tmr_count;
    chk(b == 8'(a + 8'd40), "R6 sync rate", b, 8'(a + 8'd40));
    bwrite(3'd4, 8'h00); wait_idle("R6 stop idle");

    // R6 deferred select
    bwrite(3'd2, 8'h33);
    bwrite(3'd5, 8'h20);
    bread(3'd5, r); chk(r == busy_bit(2), "R6 deferred", r, busy_bit(2));
    wait_idle("R6 idle");
    repeat (3) @(negedge clk);
    bread(3'd5, r); chk(r == stat_exp(0, 1, 0), "R6 applied", r, stat_exp(0, 1, 0));

    // R3 random loads, async clock; R2 busy visible while crossing
    for (int k = 0; k < 6; k++) begin
      v = 8'($urandom);
      bwrite(3'd0, v);
      bread(3'd5, r); chk(r == (8'h20 | busy_bit(0)), "R2 busy async", r, 8'h20 | busy_bit(0));
      wait_idle("R3 async idle");
      chk(tmr_count == v, "R3 cnt async", tmr_count, v);
      bwrite(3'd2, v); wait_idle("R3 cmpB idle");
      chk(cmp_b_hit == 1'b1, "R3 hitB async", cmp_b_hit, 1);
    end

    // R6 async rate, R8 up-count overflow
    bwrite(3'd3, 8'h00); bwrite(3'd0, 8'hF0); wait_idle("R8 setup");
    bwrite(3'd7, 8'h01); bwrite(3'd6, 8'h01); gie = 1'b1;
    bwrite(3'd4, 8'h01); wait_idle("R8 run");
    @(negedge tclk_async); a = tmr_count;
    repeat (4) @(negedge tclk_async); b = tmr_count;
    chk(b == 8'(a + 8'd4), "R6 async rate", b, 8'(a + 8'd4));
    wait_flag("R8 flag");
    chk(irq == 1'b1, "R11 irq on", irq, 1);
    gie = 1'b0; @(negedge clk);
    chk(irq == 1'b0, "R11 gie off", irq, 0);
    gie = 1'b1;
    bwrite(3'd6, 8'h00); @(negedge clk);
    chk(irq == 1'b0, "R11 mask off", irq, 0);
    bwrite(3'd6, 8'h01);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    bread(3'd7, r); chk(r[0] == 1'b0, "R10 ack clear", r, 0);
    repeat (100) @(negedge tclk_async);
    bread(3'd7, r); chk(r[0] == 1'b0, "R8 once per wrap", r, 0);
    wait_flag("R8 second wrap");
    bwrite(3'd7, 8'h01);
    bread(3'd7, r); chk(r[0] == 1'b0, "R10 w1c clear", r, 0);

    // R9 up/down mode
    bwrite(3'd4, 8'h00); wait_idle("R9 stop");
    bwrite(3'd3, 8'h01); bwrite(3'd0, 8'hF0); wait_idle("R9 setup");
    bwrite(3'd7, 8'h01);
    bwrite(3'd4, 8'h01); wait_idle("R9 run");
    n = 0;
    do begin @(posedge tclk_async); #1; n++; end while (tmr_count != 8'hFF && n < 1000);
    chk(tmr_count == 8'hFF, "R9 reach top", tmr_count, 8'hFF);
    repeat (20) @(negedge tclk_async);
    bread(3'd7, r); chk(r[0] == 1'b0, "R9 no flag at top", r, 0);
    chk(tmr_count < 8'hFF && tmr_count > 8'hE0, "R9 counting down", tmr_count, 8'hEB);
    wait_flag("R9 flag at bottom");
    chk(tmr_count < 8'h10, "R9 turn at zero", tmr_count, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule